// File: doc/BRIEF.md
# Configurable Three-Input Programmable Logic Array

This block is a small programmable logic array. It has three logic inputs, four product terms and two outputs. Every connection point is held in a configuration register and stands in for a fuse. A set bit means the connection is intact and a clear bit means it is blown. The AND plane picks, for each product term, which true and complemented input literals take part. The OR plane picks which product terms feed each output. A per-output inversion bit passes the sum through an XOR stage, so either a function or its complement can be realised. All four products are shared and may feed both outputs.

The configuration is 34 bits wide. It is written either as a whole word in one cycle, or one bit per cycle through a serial path that takes the lowest bit first. Writes happen only while the configuration enable is high. Between writes the configuration is held. The path from the logic inputs to the outputs has no register in it.

Top module: `pla_array`

## Requirements
- R1: After reset every AND-plane and OR-plane connection is intact (set) and both inversion bits are clear. As a result, both outputs read 0 for all eight input values.
- R2: While `cfg_en` is low, `cfg_load` and `cfg_shift` have no effect, and the configuration and outputs stay unchanged.
- R3: With `cfg_en` high and `cfg_load` high, `cfg_word` replaces the whole configuration at the clock edge. When `cfg_load` and `cfg_shift` are both high, the parallel load wins.
- R4: With `cfg_en` high, `cfg_shift` high and `cfg_load` low, the configuration shifts one place toward bit 0 and `cfg_bit` enters at bit 33. After 34 such cycles, the first bit shifted in sits at bit 0.
- R5: Configuration layout:
  - Bits [23:0] form the AND mask. Product p uses bits [6p+5:6p]. Within those bits, bit 6p+2i connects input i true and bit 6p+2i+1 connects input i complemented.
  - Bits [31:24] form the OR mask. Bit 24+4o+p connects product p to output o.
  - Bit 32+o inverts output o.
- R6: A product term is the AND of its connected literals. A product term with no literal connected evaluates to 1.
- R7: A product term that connects both the true and the complemented literal of any input evaluates to 0 for every input value.
- R8: Each output is the OR of the products its mask selects. One product may feed both outputs, and an output that selects no product has a sum of 0.
- R9: When an output's inversion bit is set, the output is the complement of its sum of products.
- R10: A change on `pla_in` reaches `pla_out` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high reset to the unprogrammed state |
| cfg_en | input | 1 | Configuration write enable |
| cfg_load | input | 1 | Parallel write strobe |
| cfg_shift | input | 1 | Serial shift strobe |
| cfg_word | input | 34 | Parallel configuration word |
| cfg_bit | input | 1 | Serial configuration bit |
| pla_in | input | 3 | Logic inputs; bit i is input i |
| pla_out | output | 2 | Logic outputs; bit o is output o |

## Verification
The hardest cases to reach from the ports are products that must behave as constants, namely an empty product and one with a conflicting literal pair. Two other cases are hard as well: a single product shared by two outputs with opposite inversion, and a word that arrives through 34 serial cycles. Each of these is reached by writing a crafted configuration word, through the parallel path or bit by bit through the serial path. All eight input values are then swept, and every output is compared with a truth table that the bench computes from the word itself. Blocked writes and the load-over-shift priority are shown by sweeping the outputs again after those writes.

// File: rtl/pla_pkg.sv
package pla_pkg;

    localparam int PLA_IN   = 3;
    localparam int PLA_PROD = 4;
    localparam int PLA_OUT  = 2;

    localparam int LIT_W  = 2 * PLA_IN;
    localparam int AND_W  = LIT_W * PLA_PROD;
    localparam int OR_W   = PLA_PROD * PLA_OUT;
    localparam int CFG_W  = AND_W + OR_W + PLA_OUT;

    typedef enum logic [1:0] {
        WR_HOLD  = 2'd0,
        WR_SHIFT = 2'd1,
        WR_LOAD  = 2'd2
    } wr_op_e;

    // Lowest field sits at bit 0 of the packed word.
    typedef struct packed {
        logic [PLA_OUT-1:0] inv;
        logic [OR_W-1:0]    or_m;
        logic [AND_W-1:0]   and_m;
    } pla_cfg_t;

    function automatic wr_op_e pick_op(input logic en, input logic load, input logic shift);
        if (!en)        return WR_HOLD;
        else if (load)  return WR_LOAD;
        else if (shift) return WR_SHIFT;
        else            return WR_HOLD;
    endfunction

    function automatic pla_cfg_t cfg_blank();
        pla_cfg_t c;
        c.and_m = '1;
        c.or_m  = '1;
        c.inv   = '0;
        return c;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic             shift,
    input  logic [CFG_W-1:0] word,
    input  logic             ser_bit,
    output pla_cfg_t         cfg_q
);

    wr_op_e   op;
    pla_cfg_t cfg_d;

    always_comb begin
        op = pick_op(en, load, shift);
        unique case (op)
            WR_LOAD:  cfg_d = pla_cfg_t'(word);
            WR_SHIFT: cfg_d = pla_cfg_t'({ser_bit, cfg_q[CFG_W-1:1]});
            default:  cfg_d = cfg_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= cfg_blank();
        else     cfg_q <= cfg_d;
    end

    // R2: no write while the enable is low
    a_r2_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cfg_q));

    // R3: a parallel write takes the whole word, even with shift also high
    a_r3_parallel_load: assert property (@(posedge clk) disable iff (rst)
        (en && load) |=> (cfg_q == $past(word)));

    // R4: a serial write moves the word down and enters the new bit at the top
    a_r4_serial_shift: assert property (@(posedge clk) disable iff (rst)
        (en && shift && !load) |=>
            (cfg_q[CFG_W-1] == $past(ser_bit)) &&
            (cfg_q[CFG_W-2:0] == $past(cfg_q[CFG_W-1:1])));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = 3,
    parameter int N_PROD = 4,
    localparam int LW    = 2 * N_IN
) (
    input  logic [LW*N_PROD-1:0] and_m,
    input  logic [N_IN-1:0]      x,
    output logic [N_PROD-1:0]    prod
);

    logic [LW-1:0] lits;

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            assign lits[2*i]   = x[i];
            assign lits[2*i+1] = ~x[i];
        end
        for (genvar p = 0; p < N_PROD; p++) begin : g_prod
            // A blown connection forces that term input to 1.
            assign prod[p] = &(lits | ~and_m[p*LW +: LW]);
        end
    endgenerate

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_PROD = 4,
    parameter int N_OUT  = 2
) (
    input  logic [N_PROD*N_OUT-1:0] or_m,
    input  logic [N_OUT-1:0]        inv,
    input  logic [N_PROD-1:0]       prod,
    output logic [N_OUT-1:0]        y
);

    generate
        for (genvar o = 0; o < N_OUT; o++) begin : g_out
            logic sum;
            assign sum  = |(prod & or_m[o*N_PROD +: N_PROD]);
            assign y[o] = sum ^ inv[o];
        end
    endgenerate

endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_en,
    input  logic               cfg_load,
    input  logic               cfg_shift,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic               cfg_bit,
    input  logic [PLA_IN-1:0]  pla_in,
    output logic [PLA_OUT-1:0] pla_out
);

    pla_cfg_t            cfg;
    logic [PLA_PROD-1:0] prod;

    pla_cfg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg_en),
        .load    (cfg_load),
        .shift   (cfg_shift),
        .word    (cfg_word),
        .ser_bit (cfg_bit),
        .cfg_q   (cfg)
    );

    pla_and_plane #(.N_IN(PLA_IN), .N_PROD(PLA_PROD)) u_and (
        .and_m (cfg.and_m),
        .x     (pla_in),
        .prod  (prod)
    );

    pla_or_plane #(.N_PROD(PLA_PROD), .N_OUT(PLA_OUT)) u_or (
        .or_m (cfg.or_m),
        .inv  (cfg.inv),
        .prod (prod),
        .y    (pla_out)
    );

    generate
        for (genvar p = 0; p < PLA_PROD; p++) begin : g_chk_prod
            logic [PLA_IN-1:0] clash;
            for (genvar i = 0; i < PLA_IN; i++) begin : g_pair
                assign clash[i] = cfg.and_m[p*LIT_W + 2*i] & cfg.and_m[p*LIT_W + 2*i + 1];
            end
            // R7: a literal pair makes the product constant 0
            a_r7_conflict_kills_product: assert property (@(posedge clk) disable iff (rst)
                (|clash) |-> !prod[p]);
            // R6: an empty product is constant 1
            a_r6_empty_product_true: assert property (@(posedge clk) disable iff (rst)
                (cfg.and_m[p*LIT_W +: LIT_W] == '0) |-> prod[p]);
        end
        for (genvar o = 0; o < PLA_OUT; o++) begin : g_chk_out
            // R8/R9: an output with no product equals its inversion bit
            a_r9_unused_output_follows_inv: assert property (@(posedge clk) disable iff (rst)
                (cfg.or_m[o*PLA_PROD +: PLA_PROD] == '0) |-> (pla_out[o] == cfg.inv[o]));
        end
    endgenerate

endmodule

// File: tb/test_pla_array.sv
module test_pla_array;

    localparam int W = 34;

    logic         clk = 1'b0;
    logic         rst;
    logic         cfg_en, cfg_load, cfg_shift, cfg_bit;
    logic [W-1:0] cfg_word;
    logic [2:0]   pla_in;
    logic [1:0]   pla_out;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    pla_array i_pla_array (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_load(cfg_load),
        .cfg_shift(cfg_shift), .cfg_word(cfg_word), .cfg_bit(cfg_bit),
        .pla_in(pla_in), .pla_out(pla_out)
    );

    // Truth model straight from the R5 layout and R6..R9
    function automatic logic [1:0] model(input logic [W-1:0] w, input logic [2:0] x);
        logic [1:0] r;
        logic [3:0] pr;
        for (int p = 0; p < 4; p++) begin
            pr[p] = 1'b1;
            for (int i = 0; i < 3; i++) begin
                if (w[p*6 + 2*i]     && !x[i]) pr[p] = 1'b0;
                if (w[p*6 + 2*i + 1] &&  x[i]) pr[p] = 1'b0;
            end
        end
        for (int o = 0; o < 2; o++) begin
            r[o] = 1'b0;
            for (int p = 0; p < 4; p++) if (w[24 + 4*o + p] && pr[p]) r[o] = 1'b1;
            r[o] = r[o] ^ w[32 + o];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] mk(input logic [23:0] a, input logic [7:0] o, input logic [1:0] v);
        return {v, o, a};
    endfunction

    task automatic check(input string req, input logic [1:0] exp, input logic [2:0] x);
        checks++;
        if (pla_out !== exp) begin
            failures++;
            $display("FAIL %s in=%b actual=%b expected=%b", req, x, pla_out, exp);
        end
    endtask

    // R10: outputs follow the input with no clock edge between
    task automatic sweep(input string req, input logic [W-1:0] w);
        for (int x = 0; x < 8; x++) begin
            pla_in = x[2:0];
            #1;
            check(req, model(w, x[2:0]), x[2:0]);
        end
    endtask

    task automatic load_par(input logic [W-1:0] w);
        @(negedge clk);
        cfg_en = 1'b1; cfg_load = 1'b1; cfg_word = w;
        @(negedge clk);
        cfg_en = 1'b0; cfg_load = 1'b0;
    endtask

    task automatic t_reset();
        sweep("R1", {2'b00, 8'hFF, 24'hFFFFFF});
    endtask

    task automatic t_majority();
        // p0=A&B p1=A&C p2=B&C p3=~A~B~C; out0 = ~(all), out1 = majority
        logic [W-1:0] w;
        w = mk({6'b101010, 6'b010100, 6'b010001, 6'b000101}, {4'b0111, 4'b1111}, 2'b01);
        load_par(w);
        sweep("R3_R5_R8_R9", w);
    endtask

    task automatic t_empty();
        logic [W-1:0] w;
        w = mk({6'b000011, 6'b001000, 6'b110000, 6'b000000}, {4'b0000, 4'b0001}, 2'b10);
        load_par(w);
        sweep("R6", w);
    endtask

    task automatic t_conflict();
        logic [W-1:0] w;
        w = mk({6'b000000, 6'b110000, 6'b000111, 6'b000001}, {4'b0010, 4'b0110}, 2'b10);
        load_par(w);
        sweep("R7", w);
    endtask

    task automatic t_shared();
        logic [W-1:0] w;
        w = mk({6'b000000, 6'b000000, 6'b100000, 6'b001001}, {4'b0011, 4'b0011}, 2'b10);
        load_par(w);
        sweep("R8_R9", w);
    endtask

    task automatic t_serial();
        logic [W-1:0] w;
        w = mk({6'b011000, 6'b000110, 6'b100001, 6'b010010}, {4'b1100, 4'b0101}, 2'b01);
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            cfg_en = 1'b1; cfg_shift = 1'b1; cfg_bit = w[k];
        end
        @(negedge clk);
        cfg_en = 1'b0; cfg_shift = 1'b0;
        sweep("R4", w);
    endtask

    task automatic t_disabled();
        logic [W-1:0] keep;
        keep = mk({6'b000101, 6'b000000, 6'b000000, 6'b000010}, {4'b1000, 4'b0001}, 2'b00);
        load_par(keep);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            cfg_en = 1'b0; cfg_load = 1'b1; cfg_shift = 1'b1;
            cfg_word = ~keep; cfg_bit = 1'b1;
        end
        @(negedge clk);
        cfg_load = 1'b0; cfg_shift = 1'b0;
        sweep("R2", keep);
    endtask

    task automatic t_priority();
        logic [W-1:0] w;
        w = mk({6'b000000, 6'b000000, 6'b000000, 6'b010000}, {4'b0000, 4'b0001}, 2'b00);
        @(negedge clk);
        cfg_en = 1'b1; cfg_load = 1'b1; cfg_shift = 1'b1; cfg_bit = 1'b1; cfg_word = w;
        @(negedge clk);
        cfg_en = 1'b0; cfg_load = 1'b0; cfg_shift = 1'b0;
        sweep("R3", w);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_en = 1'b0; cfg_load = 1'b0; cfg_shift = 1'b0;
        cfg_bit = 1'b0; cfg_word = '0; pla_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_majority();
        t_empty();
        t_conflict();
        t_shared();
        t_serial();
        t_disabled();
        t_priority();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule